// File: doc/BRIEF.md
# Serial Clock-Calendar Register Target

This block is the serial-bus face of a real-time clock. A host reaches a 16-byte register space over a four-wire serial link. The link runs in SPI mode 1: the clock idles low, the target changes its output on the rising edge, and both sides sample on the falling edge. The select line is active high. Every transaction opens with a command byte. Its upper nibble holds a register address and bits 3:2 pick the operation. A single operation moves one data byte and then expects a new command byte in the same selection. A burst operation moves data bytes from ascending addresses for as long as the select stays high, and the address rolls over from 15 back to 0.

Addresses 0 to 6 (seconds, minutes, hours, weekday, day, month, year) belong to the external timekeeping counters. Reads of these addresses return the counters' live bytes. A write to one of them raises a one-cycle load strobe toward the counters. When a burst read starts, all seven time bytes are frozen into a shadow copy, so a carry in the middle of the transfer cannot tear the reading. Addresses 7 to 15 are held inside the block. Address 14 is the first control register and address 15 is the second. In address 15, bit 4 (oscillator stopped) and bit 6 (supply low) are status flags: hardware sets them, and writing a 0 clears them, while writing a 1 leaves them as they are.

The serial inputs are synchronised into the system clock. A four-state controller tracks the transaction. ST_IDLE moves to ST_CMD when the select rises. ST_CMD moves to ST_READ or ST_WRITE when a command byte completes. ST_READ and ST_WRITE return to ST_CMD when a single-mode data byte completes, and remain in place during a burst. Any state goes to ST_IDLE when the select falls.

Top module: `rtc_spi_regs`

## Requirements
- R1: After reset, spi_miso is low and ld_valid is low.
- R2: The command byte's bits 7:4 are the address and bits 3:2 the operation: 2'b10 single write, 2'b11 single read, 2'b00 burst write, 2'b01 burst read. Bits 1:0 have no effect.
- R3: Data moves MSB first. The target updates spi_miso after a rising spi_sclk, and the host samples it on the falling edge. spi_miso is low while spi_cs is low, and it reads 0x00 during every command byte.
- R4: A single operation transfers exactly one data byte. The next byte in the same selection is decoded as a new command, and no data is shifted out during a write's data byte.
- R5: In a burst, each further data byte uses the next address, and the address wraps from 15 to 0.
- R6: A write to address 0–6 makes ld_valid high for one cycle, carrying that address on ld_addr and the byte on ld_data. A write to address 7–14 is stored and read back unchanged.
- R7: A read of address n in 0–6 returns time_live[8n+7:8n], except that bit 7 of address 0 always reads 0.
- R8: All time bytes read during a burst read come from a copy of time_live taken when the command byte completes. Later changes to time_live do not affect them.
- R9: In address 15, a flag_set pulse sets bits 4 and 6 and has no effect on the other bits. A write clears each of these two flags where the written bit is 0 and keeps it where the written bit is 1.
- R10: Dropping spi_cs ends the transaction and clears the bit count, the address pointer and the controller state, even in the middle of a byte.
- R11: The bits of address 15 other than 4 and 6 take the written value directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs | input | 1 | Active-high target select |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| time_live | input | 56 | Live time bytes from the counters, byte n at bits 8n+7:8n |
| flag_set | input | 8 | Status set pulses, only bits 4 and 6 used |
| ld_valid | output | 1 | One-cycle strobe for a time-register write |
| ld_addr | output | 4 | Time register being loaded |
| ld_data | output | 8 | Byte to load into the counters |

## Verification
Every stored address from 7 to 14 gets a single write followed by a single read, each with a distinct byte. Stray values in the low command bits then expose a decode that looks at bits 1:0. A chained sequence in one selection (single read, single write, single read) separates the single and burst operations. A burst write and an 18-byte burst read both start near the top of the map, so they test the wrap-around. During the burst read time_live is changed, so a read from the live bytes and a read from the snapshot give different answers. A sequence of writes to address 15 (0x57, 0x47, 0x00) after a flag pulse separates write-zero-to-clear from a plain store. An aborted three-bit transfer exposes a bit counter that is not cleared.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              spi_miso,
    output logic              cs_act,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, mosi_sync;
    logic sclk_prev, sclk_s, mosi_s, sclk_rise, sclk_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sr, tx_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sync   <= '0;
            sclk_sync <= '0;
            mosi_sync <= '0;
            sclk_prev <= 1'b0;
        end else begin
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], spi_cs};
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], spi_sclk};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], spi_mosi};
            sclk_prev <= sclk_s;
        end
    end

    assign cs_act    = cs_sync[SYNC_STAGES-1];
    assign sclk_s    = sclk_sync[SYNC_STAGES-1];
    assign mosi_s    = mosi_sync[SYNC_STAGES-1];
    assign sclk_rise = cs_act & sclk_s & ~sclk_prev;
    assign sclk_fall = cs_act & ~sclk_s & sclk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else begin
                if (sclk_fall) begin
                    rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt   <= '0;
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sr[DATA_W-2:0], mosi_s};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_rise) begin
                    tx_sr <= (bit_cnt == '0) ? tx_byte : {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso = cs_act & tx_sr[DATA_W-1];

    // R3
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !spi_miso);
    // R10
    bitcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 8,
    parameter int          TIME_REGS = 7,
    parameter int          CTL2_ADDR = 15,
    parameter logic [7:0]  W0C_MASK  = 8'h50
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [DATA_W-1:0]           flag_set,
    input  logic                        snap_take,
    input  logic [TIME_REGS*DATA_W-1:0] time_live,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic                        rd_use_snap,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        ld_valid,
    output logic [ADDR_W-1:0]           ld_addr,
    output logic [DATA_W-1:0]           ld_data
);
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(W0C_MASK);

    logic [TIME_REGS*DATA_W-1:0] snap_q;
    wire  [DATA_W-1:0]           ctl_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_take) snap_q <= time_live;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i < TIME_REGS) begin : g_time
            assign ctl_q[i] = '0;
        end else if (i == CTL2_ADDR) begin : g_w0c
            logic [DATA_W-1:0] q;
            logic              hit;
            assign hit = wr_en && (wr_addr == ADDR_W'(i));
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= (hit ? ((wr_data & ~FLAG_MASK) | (q & wr_data & FLAG_MASK)) : q)
                                 | (flag_set & FLAG_MASK);
            end
            assign ctl_q[i] = q;
            // R9
            w0c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && ((flag_set & FLAG_MASK) == '0)) |=>
                ((q & ~($past(q) & $past(wr_data)) & FLAG_MASK) == '0));
        end else begin : g_plain
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))   q <= wr_data;
            end
            assign ctl_q[i] = q;
        end
    end

    always_comb begin
        rd_data = ctl_q[rd_addr];
        for (int t = 0; t < TIME_REGS; t++) begin
            if (rd_addr == ADDR_W'(t)) begin
                rd_data = rd_use_snap ? snap_q[t*DATA_W +: DATA_W] : time_live[t*DATA_W +: DATA_W];
                if (t == 0) rd_data[DATA_W-1] = 1'b0;
            end
        end
    end

    assign ld_valid = wr_en && (wr_addr < ADDR_W'(TIME_REGS));
    assign ld_addr  = wr_addr;
    assign ld_data  = wr_data;

    // R7
    sec_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> !rd_data[DATA_W-1]);
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
    import rtc_spi_pkg::*;
#(
    parameter int         ADDR_W      = 4,
    parameter int         DATA_W      = 8,
    parameter int         TIME_REGS   = 7,
    parameter int         CTL2_ADDR   = 15,
    parameter logic [7:0] W0C_MASK    = 8'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_cs,
    input  logic                        spi_sclk,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    input  logic [TIME_REGS*DATA_W-1:0] time_live,
    input  logic [DATA_W-1:0]           flag_set,
    output logic                        ld_valid,
    output logic [ADDR_W-1:0]           ld_addr,
    output logic [DATA_W-1:0]           ld_data
);
    localparam int OP_LSB = DATA_W - ADDR_W - 2;

    xfer_state_e       state_q, state_d;
    logic              cs_act, byte_done;
    logic [DATA_W-1:0] rx_byte, tx_buf, rd_data;
    logic [ADDR_W-1:0] addr_q, rd_addr, cmd_addr;
    logic              burst_q, cmd_read, cmd_single, snap_take, rd_use_snap;
    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    assign cmd_addr   = rx_byte[DATA_W-1 -: ADDR_W];
    assign cmd_read   = rx_byte[OP_LSB];
    assign cmd_single = rx_byte[OP_LSB+1];

    rtc_spi_shifter #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .tx_byte(tx_buf), .spi_miso(spi_miso),
        .cs_act(cs_act), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    assign rd_addr     = (state_q == ST_CMD) ? cmd_addr : addr_q + ADDR_W'(1);
    assign rd_use_snap = (state_q == ST_READ) && burst_q;
    assign snap_take   = (state_q == ST_CMD) && byte_done && cmd_read && !cmd_single;

    rtc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_REGS(TIME_REGS),
                  .CTL2_ADDR(CTL2_ADDR), .W0C_MASK(W0C_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_q), .wr_addr(wr_addr_q),
        .wr_data(wr_data_q), .flag_set(flag_set), .snap_take(snap_take),
        .time_live(time_live), .rd_addr(rd_addr), .rd_use_snap(rd_use_snap),
        .rd_data(rd_data), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_act) state_d = ST_CMD;
            ST_CMD:   if (byte_done) state_d = cmd_read ? ST_READ : ST_WRITE;
            ST_WRITE: if (byte_done && !burst_q) state_d = ST_CMD;
            ST_READ:  if (byte_done && !burst_q) state_d = ST_CMD;
        endcase
        if (!cs_act) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            burst_q   <= 1'b0;
            tx_buf    <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (!cs_act) begin
                addr_q  <= '0;
                burst_q <= 1'b0;
                tx_buf  <= '0;
            end else if (byte_done) begin
                unique case (state_q)
                    ST_CMD: begin
                        addr_q  <= cmd_addr;
                        burst_q <= !cmd_single;
                        tx_buf  <= cmd_read ? rd_data : '0;
                    end
                    ST_WRITE: begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= addr_q;
                        wr_data_q <= rx_byte;
                        tx_buf    <= '0;
                        if (burst_q) addr_q <= addr_q + 1'b1;
                    end
                    ST_READ: begin
                        if (burst_q) begin
                            addr_q <= addr_q + 1'b1;
                            tx_buf <= rd_data;
                        end else begin
                            tx_buf <= '0;
                        end
                    end
                    ST_IDLE: ;
                endcase
            end
        end
    end

    // R10
    idle_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == ST_IDLE));
    // R6
    load_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(state_q == ST_WRITE));
endmodule

// File: tb/rtc_spi_regs_test.sv
module rtc_spi_regs_test;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs = 1'b0, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso;
    logic [55:0] time_live;
    logic [7:0]  flag_set = 8'h00;
    logic        ld_valid;
    logic [3:0]  ld_addr;
    logic [7:0]  ld_data;

    logic [7:0] tl [7];
    logic [7:0] snap_tl [7];
    logic [7:0] mdl [16];
    logic [3:0] ld_a [32];
    logic [7:0] ld_d [32];
    int ld_cnt = 0;
    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    always_comb for (int i = 0; i < 7; i++) time_live[i*8 +: 8] = tl[i];

    rtc_spi_regs uut (
        .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .time_live(time_live),
        .flag_set(flag_set), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    always @(posedge clk) begin
        if (rst_n && ld_valid && ld_cnt < 32) begin
            ld_a[ld_cnt] = ld_addr;
            ld_d[ld_cnt] = ld_data;
            ld_cnt++;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input logic [3:0] a, input logic [1:0] op);
        return {a, op, 2'b00};
    endfunction

    function automatic void mdl_write(input int a, input logic [7:0] d);
        if (a == 15)     mdl[15] = (d & ~8'h50) | (mdl[15] & d & 8'h50);
        else if (a >= 7) mdl[a] = d;
    endfunction

    function automatic logic [7:0] exp_rd(input int a, input bit snap);
        logic [7:0] v;
        if (a < 7) begin
            v = snap ? snap_tl[a] : tl[a];
            if (a == 0) v[7] = 1'b0;
        end else v = mdl[a];
        return v;
    endfunction

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            spi_sclk = 1'b1;
            spi_mosi = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = spi_miso;
            spi_sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic cs_on();
        @(negedge clk);
        spi_cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (4) @(negedge clk);
        spi_cs = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r, v;
        int base;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        for (int i = 0; i < 7; i++) tl[i] = 8'h10 + 8'(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 miso after reset", {7'd0, spi_miso}, 8'h00);
        check("R1 no load after reset", {7'd0, ld_valid}, 8'h00);

        // R6 / R2: single write then single read of every stored address
        for (int a = 7; a <= 14; a++) begin
            v = 8'(a * 37 + 5);
            cs_on();
            xfer(cmd(4'(a), 2'b10) | 8'(a & 3), r);
            xfer(v, r);
            cs_off();
            mdl_write(a, v);
            cs_on();
            xfer(cmd(4'(a), 2'b11) | 8'((a + 1) & 3), r);
            check("R3 zero during command byte", r, 8'h00);
            xfer(8'h00, r);
            check($sformatf("R6 R2 readback addr %0d", a), r, exp_rd(a, 0));
            cs_off();
        end

        // R6: single write to a time register drives the load port
        base = ld_cnt;
        cs_on();
        xfer(cmd(4'd3, 2'b10), r);
        xfer(8'h42, r);
        cs_off();
        check("R6 load count", 8'(ld_cnt - base), 8'd1);
        check("R6 load addr", {4'd0, ld_a[base]}, 8'h03);
        check("R6 load data", ld_d[base], 8'h42);

        // R4: chained single operations in one selection
        cs_on();
        xfer(cmd(4'd15, 2'b11), r);
        xfer(8'h00, r);
        check("R4 single read of addr 15", r, exp_rd(15, 0));
        xfer(cmd(4'd9, 2'b10), r);
        check("R4 zero during second command", r, 8'h00);
        xfer(8'hA5, r);
        check("R4 no data during write byte", r, 8'h00);
        mdl_write(9, 8'hA5);
        xfer(cmd(4'd9, 2'b11), r);
        xfer(8'h00, r);
        check("R4 third command reads new value", r, 8'hA5);
        cs_off();

        // R5: burst write wrapping 13,14,15,0,1
        base = ld_cnt;
        cs_on();
        xfer(cmd(4'd13, 2'b00), r);
        xfer(8'h11, r); mdl_write(13, 8'h11);
        xfer(8'h22, r); mdl_write(14, 8'h22);
        xfer(8'h5F, r); mdl_write(15, 8'h5F);
        xfer(8'h33, r);
        xfer(8'h44, r);
        cs_off();
        check("R5 wrap load count", 8'(ld_cnt - base), 8'd2);
        check("R5 wrap load addr 0", {4'd0, ld_a[base]}, 8'h00);
        check("R5 wrap load data 0", ld_d[base], 8'h33);
        check("R5 wrap load addr 1", {4'd0, ld_a[base + 1]}, 8'h01);
        check("R5 wrap load data 1", ld_d[base + 1], 8'h44);

        // R8 / R7 / R5: burst read across wrap with the time changing mid-transfer
        tl[0] = 8'hD9;
        for (int i = 1; i < 7; i++) tl[i] = 8'h20 + 8'(i * 3);
        for (int i = 0; i < 7; i++) snap_tl[i] = tl[i];
        cs_on();
        xfer(cmd(4'd12, 2'b01), r);
        for (int k = 0; k < 18; k++) begin
            xfer(8'h00, r);
            check($sformatf("R8 R5 burst byte %0d addr %0d", k, (12 + k) % 16),
                  r, exp_rd((12 + k) % 16, 1));
            if (k == 1) for (int i = 0; i < 7; i++) tl[i] = 8'h50 + 8'(i);
        end
        cs_off();

        // R7: single read of seconds uses live value with bit 7 masked
        tl[0] = 8'hB7;
        cs_on();
        xfer(cmd(4'd0, 2'b11), r);
        xfer(8'h00, r);
        check("R7 live seconds masked", r, 8'h37);
        xfer(cmd(4'd5, 2'b11), r);
        xfer(8'h00, r);
        check("R7 live month", r, tl[5]);
        cs_off();

        // R9 / R11: write-zero-to-clear flags in address 15
        cs_on(); xfer(cmd(4'd15, 2'b10), r); xfer(8'h00, r); cs_off();
        mdl_write(15, 8'h00);
        @(negedge clk); flag_set = 8'hFF;
        @(negedge clk); flag_set = 8'h00;
        mdl[15] = mdl[15] | 8'h50;
        foreach (mdl[i]) if (i == 15) begin end
        for (int s = 0; s < 4; s++) begin
            cs_on();
            xfer(cmd(4'd15, 2'b11), r);
            xfer(8'h00, r);
            check($sformatf("R9 R11 addr 15 step %0d", s), r, mdl[15]);
            cs_off();
            v = (s == 0) ? 8'h57 : (s == 1) ? 8'h47 : 8'h00;
            if (s < 3) begin
                cs_on(); xfer(cmd(4'd15, 2'b10), r); xfer(v, r); cs_off();
                mdl_write(15, v);
            end
        end

        // R10: abort after three bits, then a clean transaction
        cs_on();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); spi_sclk = 1'b1; spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk); spi_sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_off();
        check("R10 miso low after abort", {7'd0, spi_miso}, 8'h00);
        cs_on();
        xfer(cmd(4'd9, 2'b11), r);
        check("R10 zero during command after abort", r, 8'h00);
        xfer(8'h00, r);
        check("R10 read after abort", r, 8'hA5);
        cs_off();

        summary();
        $finish;
    end
endmodule